// File: doc/BRIEF.md
# Thermal Sensor Two-Wire Register Slave

This block is the serial front end of a thermal sensor. It watches the shared clock and data wires of a two-wire bus and samples them on a fast system clock. It recognises its own 7-bit device address and exposes a bank of 16-bit registers through a plain register port. The host first writes an 8-bit pointer. It may follow the pointer with a data pair, high byte first, which the block turns into one write strobe. A read returns the pointed register, high byte then low byte. Bytes travel most significant bit first. The block can only pull the data wire low. It never drives it high.

Three strap pins set the low part of the address. They are sampled again at every START, so a board can change them between accesses. An optional bus timeout watches the clock line while a transfer is in progress. If the clock stays low for too long, the block drops the transfer and releases the data wire. Short pulses on either wire are filtered out before any edge is seen.

Top module: `tsense_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0011 followed by strap[2], strap[1], strap[0]. Any other address gets no acknowledge, and every byte after it is ignored until the next START.
- R2: The straps are captured at every START and every repeated START. A repeated START with a changed strap value matches the new address, and the old address is then refused.
- R3: A write of address (R/W bit 0), pointer, high byte and low byte acknowledges all four bytes. It gives exactly one single-cycle reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to {high, low}.
- R4: A write that stops after the pointer produces no reg_wr. A following read with R/W bit 1 and no new pointer returns the register at that pointer.
- R5: A read sends reg_rdata[15:8] and then reg_rdata[7:0], each most significant bit first. A host NACK on the first byte ends the read, and SDA stays released afterwards.
- R6: SDA is only ever pulled low through sda_oe (1 = drive low). sda_oe is 0 whenever the block is idle.
- R7: With tmo_en high, if SCL stays low for TMO_CYCLES system clocks during a transfer, the block goes idle and releases SDA. A later transfer works normally.
- R8: With tmo_en low, a long SCL-low period does not abort the transfer.
- R9: A pulse on SCL or SDA that lasts fewer than FILT system clocks has no effect on the transfer.
- R10: After reset, sda_oe and reg_wr are 0.
- R11: A third data byte in a write gets no acknowledge and causes no further reg_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe | output | 1 | 1 pulls the data wire low |
| strap | input | 3 | Low address bits, strap[2] most significant |
| tmo_en | input | 1 | Enables the clock-low timeout |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Data of register at reg_addr |

## Verification
Two functions can act at the same instant: the strap pins change, and a repeated START samples them. The bench changes the straps in the middle of an acknowledged access and then issues a repeated START. The new address must be acknowledged, and a later access with the old address must be refused. The timeout and the acknowledge drive can also overlap: the bench holds SCL low while the block is pulling SDA low for an acknowledge. It then checks whether that pull-down is dropped or kept, for each setting of tmo_en.

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave #(
  parameter logic [3:0] ADDR_HI    = 4'b0011,
  parameter int         FILT       = 4,
  parameter int         TMO_CYCLES = 3_125_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap,
  input  logic        tmo_en,
  output logic [7:0]  reg_addr,
  output logic        reg_wr,
  output logic [15:0] reg_wdata,
  input  logic [15:0] reg_rdata
);

  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WHI, S_WLO, S_RD} st_t;

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;
  st_t             st;
  logic            in_ack, rw, second, mack;
  logic [3:0]      bit_cnt;
  logic [7:0]      sreg, wr_hi;
  logic [15:0]     tx;
  logic [2:0]      strap_q;
  logic [TW-1:0]   tmo_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  wire scl_rise  = scl_f & ~scl_d;
  wire scl_fall  = ~scl_f & scl_d;
  wire start_det = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  wire addr_ok   = sreg[7:1] == {ADDR_HI, strap_q};
  wire rx_st     = st inside {S_ADDR, S_PTR, S_WHI, S_WLO};
  wire tmo_hit   = tmo_cnt == TW'(TMO_CYCLES);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (!tmo_en || scl_f || st == S_IDLE) tmo_cnt <= '0;
    else if (!tmo_hit) tmo_cnt <= tmo_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; in_ack <= 1'b0; rw <= 1'b0; second <= 1'b0; mack <= 1'b0;
      bit_cnt <= '0; sreg <= '0; wr_hi <= '0; tx <= '0; strap_q <= '0;
      sda_oe <= 1'b0; reg_addr <= '0; reg_wr <= 1'b0; reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (start_det) begin
        st <= S_ADDR; bit_cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
        strap_q <= strap;
      end else if (stop_det || tmo_hit) begin
        st <= S_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (in_ack) mack <= ~sda_f;
          else begin
            bit_cnt <= bit_cnt + 4'd1;
            if (rx_st) sreg <= {sreg[6:0], sda_f};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; bit_cnt <= '0; sda_oe <= 1'b0;
            case (st)
              S_ADDR: if (rw) begin
                        st <= S_RD; tx <= reg_rdata; sda_oe <= ~reg_rdata[15]; second <= 1'b0;
                      end else st <= S_PTR;
              S_PTR:  st <= S_WHI;
              S_WHI:  st <= S_WLO;
              S_RD:   if (mack && !second) begin
                        second <= 1'b1; sda_oe <= ~tx[15];
                      end else st <= S_IDLE;
              default: st <= S_IDLE;
            endcase
          end else if (bit_cnt == 4'd8) begin
            if (st == S_RD) begin
              sda_oe <= 1'b0; in_ack <= 1'b1; tx <= {tx[14:0], 1'b0};
            end else if (st == S_ADDR && !addr_ok) begin
              st <= S_IDLE;
            end else begin
              in_ack <= 1'b1; sda_oe <= 1'b1;
              case (st)
                S_ADDR:  rw <= sreg[0];
                S_PTR:   reg_addr <= sreg;
                S_WHI:   wr_hi <= sreg;
                S_WLO:   begin reg_wr <= 1'b1; reg_wdata <= {wr_hi, sreg}; end
                default: ;
              endcase
            end
          end else if (st == S_RD) begin
            tx <= {tx[14:0], 1'b0};
            sda_oe <= ~tx[14];
          end
        end
      end
    end

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R2
  strap_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && !sda_oe && strap_q == $past(strap)));

  // R7
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (st == S_IDLE && !sda_oe));

  // R8
  timeout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |=> !tmo_hit);

  // R1
  addr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !in_ack && bit_cnt == 4'd8 && st == S_ADDR && !addr_ok
     && !start_det && !stop_det && !tmo_hit) |=> (st == S_IDLE && !sda_oe));

endmodule

// File: tb/test_tsense_i2c_slave.sv
module test_tsense_i2c_slave;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, tmo_en = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] bank [16];
  logic [15:0] expb [16];
  logic [23:0] wq[$];
  int checks = 0, errors = 0;
  bit done = 0;

  wire sda_line = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_addr[3:0]];

  always #4 clk = ~clk;

  tsense_i2c_slave #(.TMO_CYCLES(2000)) i_tsense_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .tmo_en(tmo_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes (R3, R11)
  always @(negedge clk) if (rst_n && reg_wr) begin
    bank[reg_addr[3:0]] = reg_wdata;
    if (wq.size() == 0) chk(0, "R3 unexpected reg_wr", {8'h0, reg_addr, reg_wdata}, 0);
    else begin
      logic [23:0] e;
      e = wq.pop_front();
      chk({reg_addr, reg_wdata} == e, "R3 write item", {8'h0, reg_addr, reg_wdata}, {8'h0, e});
    end
  end

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask

  task automatic put_bit(input logic b, input logic glitch);
    sda_m = b; wt(Q/2);
    if (glitch) begin scl_m = 1; wt(2); scl_m = 0; end
    wt(Q - Q/2); scl_m = 1; wt(Q);
    if (glitch) begin sda_m = ~b; wt(2); sda_m = b; end
    wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gi, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], i == gi);
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); @(negedge clk); ack = ~sda_line;
    wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1; wt(Q); @(negedge clk); b = {b[6:0], sda_line}; wt(Q); scl_m = 0; wt(Q);
    end
    sda_m = ~mack; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q); sda_m = 1;
  endtask

  task automatic bstart();
    sda_m = 1; wt(Q); scl_m = 1; wt(2*Q); sda_m = 0; wt(2*Q); scl_m = 0; wt(Q);
  endtask

  task automatic bstop();
    sda_m = 0; wt(Q); scl_m = 1; wt(2*Q); sda_m = 1; wt(2*Q);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [15:0] d, input int gi);
    logic ack;
    wq.push_back({p, d}); expb[p[3:0]] = d;
    bstart();
    send_byte({a, 1'b0}, -1, ack); chk(ack, "R1 address ack", ack, 1);
    send_byte(p, -1, ack);         chk(ack, "R3 pointer ack", ack, 1);
    send_byte(d[15:8], gi, ack);   chk(ack, "R3 high ack", ack, 1);
    send_byte(d[7:0], -1, ack);    chk(ack, "R3 low ack", ack, 1);
    bstop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] p, input logic [15:0] exp);
    logic ack; logic [7:0] hi, lo;
    bstart();
    send_byte({a, 1'b0}, -1, ack); send_byte(p, -1, ack);
    bstart();
    send_byte({a, 1'b1}, -1, ack); chk(ack, "R5 read address ack", ack, 1);
    recv_byte(1, hi); recv_byte(0, lo);
    bstop();
    chk({hi, lo} == exp, "R5 read data", {hi, lo}, exp);
  endtask

  initial begin
    logic ack; logic [7:0] hi, lo;
    for (int i = 0; i < 16; i++) begin bank[i] = 16'hC0DE ^ (16'(i) * 16'h0101); expb[i] = bank[i]; end
    wt(5); rst_n = 1; wt(2); @(negedge clk);
    chk(!sda_oe && !reg_wr, "R10 reset outputs", {sda_oe, reg_wr}, 0);
    wt(20);

    do_write(7'h18, 8'h03, 16'h1234, -1);
    do_read(7'h18, 8'h03, 16'h1234);
    do_read(7'h18, 8'h05, expb[5]);

    // R4 pointer-only write then current-pointer read
    bstart(); send_byte(8'h30, -1, ack); send_byte(8'h07, -1, ack); bstop();
    bstart(); send_byte(8'h31, -1, ack); recv_byte(1, hi); recv_byte(0, lo); bstop();
    chk({hi, lo} == expb[7], "R4 pointer kept", {hi, lo}, expb[7]);

    // R1 wrong address refused, following byte ignored
    bstart(); send_byte(8'h32, -1, ack); chk(!ack, "R1 mismatch nack", ack, 0);
    send_byte(8'h02, -1, ack); chk(!ack, "R1 ignored byte", ack, 0); bstop();

    // R2 strap resampled on repeated START
    strap = 3'b101;
    do_write(7'h1D, 8'h02, 16'hBEEF, -1);
    bstart(); send_byte(8'h3A, -1, ack);
    strap = 3'b010;
    bstart(); send_byte(8'h34, -1, ack); chk(ack, "R2 new strap ack", ack, 1); bstop();
    bstart(); send_byte(8'h3A, -1, ack); chk(!ack, "R2 old strap refused", ack, 0); bstop();

    // R5 host NACK on first byte ends read
    bstart(); send_byte(8'h35, -1, ack); recv_byte(0, hi);
    chk(hi == expb[2][15:8], "R5 first byte", hi, expb[2][15:8]);
    recv_byte(0, lo); chk(lo == 8'hFF && !sda_oe, "R5 released after nack", lo, 8'hFF); bstop();

    // R11 third data byte refused
    wq.push_back({8'h04, 16'h0A0B}); expb[4] = 16'h0A0B;
    bstart(); send_byte(8'h34, -1, ack); send_byte(8'h04, -1, ack);
    send_byte(8'h0A, -1, ack); send_byte(8'h0B, -1, ack);
    send_byte(8'h55, -1, ack); chk(!ack, "R11 extra byte nack", ack, 0); bstop();

    // R7 timeout during ack drive
    bstart(); for (int i = 7; i >= 0; i--) put_bit(8'h34 >> i, 0);
    wt(1000); @(negedge clk); chk(sda_oe, "R7 ack held before limit", sda_oe, 1);
    wt(2000); @(negedge clk); chk(!sda_oe, "R7 released on timeout", sda_oe, 0);
    bstop();
    do_write(7'h1A, 8'h06, 16'h6789, -1);

    // R8 timeout disabled
    tmo_en = 0;
    wq.push_back({8'h08, 16'h4242}); expb[8] = 16'h4242;
    bstart(); for (int i = 7; i >= 0; i--) put_bit(8'h34 >> i, 0);
    wt(3000); @(negedge clk); chk(sda_oe, "R8 ack kept", sda_oe, 1);
    sda_m = 1; wt(Q); scl_m = 1; wt(2*Q); scl_m = 0; wt(Q);
    send_byte(8'h08, -1, ack); send_byte(8'h42, -1, ack); send_byte(8'h42, -1, ack);
    chk(ack, "R8 transfer completed", ack, 1); bstop();
    tmo_en = 1;

    // R9 glitches inside the high byte
    do_write(7'h1A, 8'h09, 16'hA55A, 4);
    do_read(7'h1A, 8'h09, 16'hA55A);
    chk(!sda_oe, "R6 idle release", sda_oe, 0);

    wt(20);
    chk(wq.size() == 0, "R3 all writes seen", wq.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wt(190000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule